// File: doc/BRIEF.md
# Interconnect Target Agent Register Slave

This block is a small register slave that sits between an on-chip interconnect and one peripheral. It holds three 32-bit registers. The first is a read-only identifier that returns a fixed constant. The second is an agent control word, and only a fixed set of its bits can be written. The third is an agent status word that reports a request timeout. A bus master reaches the registers through a single-cycle request channel. The result of each request appears on a response channel one clock later.

The status word has one live bit, the timeout flag. A one-cycle event pulse from the interconnect sets it. Software clears it by writing the control register with bit 0 set. Bit 0 is a command only and is never stored. If an event pulse and a clearing write land in the same cycle, the flag stays set.

Only full 32-bit accesses are legal. The block refuses any of the following, raises an error with the response, and leaves every register unchanged:
- a byte or halfword access;
- a write to a read-only register;
- any access to an offset that holds no register.

Top module: `target_agent_regs`

## Requirements
- R1: After reset the control register reads 0x0000_0200, the status register reads 0x0000_0000, and no response is valid while reset is held.
- R2: A word read at offset 0x00 returns the identifier constant (parameter `ID_VALUE`, default 0x7A61_0C01) with no error.
- R3: A word write at offset 0x20 stores only the bits set in mask 0x0100_0700. Every other control bit reads back as 0.
- R4: A word write at offset 0x20 with bit 0 set clears status bit 0. Bit 0 of control always reads 0. A control write with bit 0 clear leaves status unchanged.
- R5: A one-cycle pulse on `timeout_evt` sets status bit 0. The bit stays set until a clearing write.
- R6: When `timeout_evt` and a clearing control write occur in the same cycle, status bit 0 ends up set.
- R7: An access whose `req_size` is not 2 (encoding: 0 = byte, 1 = halfword, 2 = word, 3 = reserved) responds with `rsp_err` = 1 and `rsp_rdata` = 0. It changes no register.
- R8: A word write to offset 0x00 or 0x28 responds with `rsp_err` = 1 and changes no register.
- R9: A word access to any offset other than 0x00, 0x20 and 0x28 responds with `rsp_err` = 1. A read returns 0, and a write changes no register.
- R10: `req_ready` is always 1. Every accepted request produces exactly one `rsp_valid` cycle on the next clock, and `rsp_valid` is never high otherwise.
- R11: A legal access responds with `rsp_err` = 0. A write response carries `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted; held at 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W (8) | Byte offset inside the agent |
| req_wdata | input | 32 | Write data |
| timeout_evt | input | 1 | One-cycle request-timeout event from the interconnect |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes and refused accesses |
| rsp_err | output | 1 | Access refused (bad width, read-only write or undefined offset) |

## Verification
The bench builds the block with its default parameters: an 8-bit offset field, the default identifier constant, and the default control mask and reset value. With these values all three registers are in reach, and so are the undefined holes between them (0x04 and 0x24) and all four width encodings. The bench also drives a timeout pulse in the same cycle as a clearing write, which exposes the set-over-clear priority. Back-to-back requests check the one-response-per-request rule.

// File: rtl/tagent_pkg.sv
package tagent_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned OFS_ID   = 'h00;
  localparam int unsigned OFS_CTRL = 'h20;
  localparam int unsigned OFS_STAT = 'h28;

  localparam int unsigned CLR_BIT  = 0;

endpackage

// File: rtl/tagent_decode.sv
module tagent_decode
  import tagent_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          rd_sel,
  output logic              ctrl_wr,
  output logic              acc_err
);

  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  reg_sel_e hit;
  logic     word_ok;
  logic     ro_target;

  always_comb begin
    unique case (req_addr)
      A_ID:    hit = SEL_ID;
      A_CTRL:  hit = SEL_CTRL;
      A_STAT:  hit = SEL_STAT;
      default: hit = SEL_NONE;
    endcase
  end

  assign word_ok   = (acc_size_e'(req_size) == SZ_WORD);
  assign ro_target = (hit == SEL_ID) || (hit == SEL_STAT);

  always_comb begin
    rd_sel  = SEL_NONE;
    ctrl_wr = 1'b0;
    acc_err = 1'b0;
    if (req_valid) begin
      if (!word_ok || hit == SEL_NONE) begin
        acc_err = 1'b1;
      end else if (req_write) begin
        if (ro_target) acc_err = 1'b1;
        else           ctrl_wr = 1'b1;
      end else begin
        rd_sel = hit;
      end
    end
  end

endmodule

// File: rtl/tagent_regs.sv
module tagent_regs
  import tagent_pkg::*;
#(
  parameter int unsigned    DATA_W    = 32,
  parameter logic [DATA_W-1:0] CTRL_MASK = 32'h0100_0700,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              timeout_evt,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              stat_to
);

  localparam logic [DATA_W-1:0] RST_KEEP = CTRL_RST & CTRL_MASK;

  logic clr_req;

  assign clr_req = ctrl_wr && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= RST_KEEP;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_to <= 1'b0;
    end else if (timeout_evt) begin
      stat_to <= 1'b1;
    end else if (clr_req) begin
      stat_to <= 1'b0;
    end
  end

endmodule

// File: rtl/tagent_rsp.sv
module tagent_rsp
  import tagent_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h7A61_0C01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  reg_sel_e          rd_sel,
  input  logic              acc_err,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic              stat_to,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] stat_word;

  assign stat_word = {{(DATA_W-1){1'b0}}, stat_to};

  always_comb begin
    unique case (rd_sel)
      SEL_ID:   rd_mux = ID_VALUE;
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = stat_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_mux : '0;
      rsp_err   <= req_valid && acc_err;
    end
  end

endmodule

// File: rtl/target_agent_regs.sv
module target_agent_regs
  import tagent_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 8,
  parameter logic [31:0]    ID_VALUE  = 32'h7A61_0C01,
  parameter logic [31:0]    CTRL_MASK = 32'h0100_0700,
  parameter logic [31:0]    CTRL_RST  = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              timeout_evt,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam int unsigned DATA_W = 32;

  reg_sel_e          rd_sel;
  logic              ctrl_wr;
  logic              acc_err;
  logic [DATA_W-1:0] ctrl_q;
  logic              stat_to;

  assign req_ready = 1'b1;

  tagent_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rd_sel    (rd_sel),
    .ctrl_wr   (ctrl_wr),
    .acc_err   (acc_err)
  );

  tagent_regs #(
    .DATA_W    (DATA_W),
    .CTRL_MASK (CTRL_MASK),
    .CTRL_RST  (CTRL_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .wdata       (req_wdata),
    .timeout_evt (timeout_evt),
    .ctrl_q      (ctrl_q),
    .stat_to     (stat_to)
  );

  tagent_rsp #(
    .DATA_W   (DATA_W),
    .ID_VALUE (ID_VALUE)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rd_sel    (rd_sel),
    .acc_err   (acc_err),
    .ctrl_q    (ctrl_q),
    .stat_to   (stat_to),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

endmodule

// File: rtl/target_agent_regs_chk.sv
module target_agent_regs_chk
  import tagent_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] CTRL_MASK = 32'h0100_0700
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              timeout_evt,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [31:0]       ctrl_q,
  input logic              stat_to
);

  logic word_acc;
  logic ctrl_hit;
  logic ro_hit;

  assign word_acc = req_valid && (req_size == 2'd2);
  assign ctrl_hit = (req_addr == ADDR_W'(OFS_CTRL));
  assign ro_hit   = (req_addr == ADDR_W'(OFS_ID)) || (req_addr == ADDR_W'(OFS_STAT));

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r10_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  a_r3_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == 32'h0);

  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> stat_to);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (word_acc && req_write && ctrl_hit && req_wdata[0] && !timeout_evt) |=> !stat_to);

  a_r7_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |=> (rsp_err && rsp_rdata == 32'h0 && $stable(ctrl_q)));

  a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (word_acc && req_write && ro_hit) |=> (rsp_err && $stable(ctrl_q)));

  a_r11_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

endmodule

bind target_agent_regs target_agent_regs_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_MASK (CTRL_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .timeout_evt (timeout_evt),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .ctrl_q      (ctrl_q),
  .stat_to     (stat_to)
);

// File: tb/target_agent_regs_bench.sv
module target_agent_regs_bench;

  localparam logic [31:0] ID_EXP = 32'h7A61_0C01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [7:0]  req_addr = 8'h00;
  logic [31:0] req_wdata = 32'h0;
  logic        timeout_evt = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  target_agent_regs u_target_agent_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .timeout_evt (timeout_evt),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err)
  );

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual err=%0b data=%h expected err=%0b data=%h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R10: actual unexpected response valid expected none");
      end else begin
        check(tag_q.pop_front(), {rsp_err, rsp_rdata}, exp_q.pop_front());
      end
    end
  end

  task automatic issue(input string tag, input bit wr, input logic [1:0] sz,
                       input logic [7:0] addr, input logic [31:0] wd,
                       input bit exp_err, input logic [31:0] exp_data,
                       input bit evt = 1'b0);
    exp_q.push_back({exp_err, exp_data});
    tag_q.push_back(tag);
    req_valid   = 1'b1;
    req_write   = wr;
    req_size    = sz;
    req_addr    = addr;
    req_wdata   = wd;
    timeout_evt = evt;
    @(posedge clk);
    @(negedge clk);
    req_valid   = 1'b0;
    timeout_evt = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] e);
    issue(tag, 1'b0, 2'd2, a, 32'h0, 1'b0, e);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
    issue(tag, 1'b1, 2'd2, a, d, 1'b0, 32'h0);
  endtask

  task automatic pulse_evt();
    timeout_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    timeout_evt = 1'b0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", {rsp_err, 31'h0, rsp_valid}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);

    rd("R1 ctrl reset", 8'h20, 32'h0000_0200);
    rd("R1 status reset", 8'h28, 32'h0);
    rd("R2 identifier", 8'h00, ID_EXP);

    wr("R11 ctrl write ok", 8'h20, 32'hFFFF_FFFF);
    rd("R3 R4 ctrl masked, bit0 not kept", 8'h20, 32'h0100_0700);
    wr("R11 ctrl write ok", 8'h20, 32'h0000_0100);
    rd("R3 ctrl subset", 8'h20, 32'h0000_0100);

    pulse_evt();
    rd("R5 status set by event", 8'h28, 32'h1);
    rd("R5 status held", 8'h28, 32'h1);
    wr("R11 ctrl write ok", 8'h20, 32'h0000_0400);
    rd("R4 no clear without bit0", 8'h28, 32'h1);
    wr("R11 ctrl write ok", 8'h20, 32'h0000_0001);
    rd("R4 status cleared", 8'h28, 32'h0);
    rd("R4 ctrl after clear write", 8'h20, 32'h0);

    issue("R6 event and clear together", 1'b1, 2'd2, 8'h20, 32'h0000_0201, 1'b0, 32'h0, 1'b1);
    rd("R6 event wins", 8'h28, 32'h1);
    rd("R6 ctrl stored", 8'h20, 32'h0000_0200);

    issue("R7 byte read", 1'b0, 2'd0, 8'h20, 32'h0, 1'b1, 32'h0);
    issue("R7 half read", 1'b0, 2'd1, 8'h00, 32'h0, 1'b1, 32'h0);
    issue("R7 reserved size read", 1'b0, 2'd3, 8'h28, 32'h0, 1'b1, 32'h0);
    issue("R7 half write", 1'b1, 2'd1, 8'h20, 32'h0000_0400, 1'b1, 32'h0);
    issue("R7 byte clear write", 1'b1, 2'd0, 8'h20, 32'h0000_0001, 1'b1, 32'h0);
    rd("R7 ctrl unchanged", 8'h20, 32'h0000_0200);
    rd("R7 status unchanged", 8'h28, 32'h1);

    issue("R8 write id", 1'b1, 2'd2, 8'h00, 32'h1234_5678, 1'b1, 32'h0);
    rd("R8 id unchanged", 8'h00, ID_EXP);
    issue("R8 write status", 1'b1, 2'd2, 8'h28, 32'h0, 1'b1, 32'h0);
    rd("R8 status unchanged", 8'h28, 32'h1);

    issue("R9 undefined read 0x24", 1'b0, 2'd2, 8'h24, 32'h0, 1'b1, 32'h0);
    issue("R9 undefined read 0x04", 1'b0, 2'd2, 8'h04, 32'h0, 1'b1, 32'h0);
    issue("R9 undefined write", 1'b1, 2'd2, 8'h24, 32'h0100_0001, 1'b1, 32'h0);
    rd("R9 ctrl unchanged", 8'h20, 32'h0000_0200);
    rd("R9 status unchanged", 8'h28, 32'h1);

    repeat (4) @(negedge clk);
    check("R10 all responses seen", {1'b0, 32'(exp_q.size())}, 33'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule